// File: doc/BRIEF.md
# Masked Vector Gather Sequencer

This block carries out a masked gather of 32-bit elements into a destination vector of up to 256 bits. From a 64-bit base, a vector of signed indices (32-bit or 64-bit lanes), a 2-bit scale code and a signed displacement it forms one address per lane. For each active lane it issues a single-element read over a valid/ready request port, one request at a time, and merges the returned word into the destination.

Each lane's mask element is cleared once that lane has been handled. A fault ends the operation at once and leaves the destination and mask partly updated. Starting the operation again with those partial values fetches only the lanes that remain, and produces the same result as a run that never faulted. Parts of the destination and mask that belong to no lane of the selected shape are forced to zero.

Top module: `vgather_seq`

## Requirements
- R1: A `start` pulse while idle raises `busy` on the next cycle. `busy` stays high until the operation ends. `done` is then a one-cycle pulse, and `busy` is low in that same cycle. After reset, `busy`, `done` and `req_valid` are low and `mask_out` is zero.
- R2: When an operation begins, each 32-bit mask element becomes all ones if its bit 31 is 1 and all zeros otherwise. A lane is active when bit 31 of its element is 1.
- R3: The address of lane j is `base_addr + (sext(index_j) << scale_code) + sext(disp)`, taken modulo 2^64. `scale_code` 0..3 means a factor of 1, 2, 4 or 8. A 32-bit index lane j sits at `idx_vec[32j+31:32j]` and a 64-bit index lane j sits at `idx_vec[64j+63:64j]`.
- R4: The lane count is 8 when `wide_mode`=1 and `idx64`=0, 4 when `wide_mode`=0 and `idx64`=0, 4 when `wide_mode`=1 and `idx64`=1, and 2 when `wide_mode`=0 and `idx64`=1. Destination lane j is `dest_out[32j+31:32j]`.
- R5: Lanes are handled in ascending order. At most one request is outstanding. A request that has not been accepted keeps `req_valid` high with an unchanged address.
- R6: An inactive lane issues no request, and its destination element keeps its old value. An active lane that completes receives `rsp_data`.
- R7: Destination and mask bits at or above 32 × (lane count) are zero at the end of an operation, whether it completes or faults.
- R8: An operation with no fault ends with `fault_o`=0 and `mask_out` entirely zero.
- R9: A response with `rsp_fault`=1 ends the operation with `fault_o`=1 and `fault_lane` set to that lane. Earlier lanes keep their gathered data and zero mask elements. The faulting lane keeps its old destination element and its all-ones mask element, and so does every later active lane.
- R10: `resume_o` is 1 on a fault exactly when at least one element was gathered before it.
- R11: Restarting with `dest_in`=`dest_out` and `mask_in`=`mask_out` after a fault requests only the remaining active lanes. The final destination equals that of a run without the fault.
- R12: A `start` pulse while `busy` is ignored. The running operation's requests and results are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| wide_mode | input | 1 | 1: 256-bit destination shape, 0: 128-bit |
| idx64 | input | 1 | 1: 64-bit index lanes, 0: 32-bit |
| scale_code | input | 2 | Index shift amount 0..3 |
| base_addr | input | 64 | Common base address |
| disp | input | 32 | Signed displacement |
| idx_vec | input | 256 | Index vector |
| mask_in | input | 256 | Mask vector, one 32-bit element per lane |
| dest_in | input | 256 | Old destination vector |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end pulse |
| fault_o | output | 1 | End status: 1 fault, 0 complete |
| fault_lane | output | 3 | Lane that faulted |
| resume_o | output | 1 | Fault came after at least one gathered lane |
| dest_out | output | 256 | Destination vector |
| mask_out | output | 256 | Mask vector |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Read request accepted |
| req_addr | output | 64 | Read request address |
| rsp_valid | input | 1 | Read response valid |
| rsp_data | input | 32 | Read response data |
| rsp_fault | input | 1 | Read response fault |

## Verification
The operation is captured on the first rising edge that sees `start`, so `busy` is checked at the next falling edge. Each inactive lane takes one cycle. An accepted request is answered after the bench's chosen response delay, and the lane completes on the edge that sees the response. `done` therefore rises one cycle after the last lane. The bench waits on falling edges until `done` is high, checks destination, mask, status and the logged request addresses there, and checks one falling edge later that `done` has dropped. The sweep covers every mode, every scale and several mask patterns, with different response delays and accept stalls, so results never depend on fixed latencies.

// File: rtl/vg_pkg.sv
package vg_pkg;
   typedef enum logic [1:0] {
      VG_IDLE = 2'd0,
      VG_SCAN = 2'd1,
      VG_WAIT = 2'd2
   } vg_state_e;
endpackage

// File: rtl/vg_addr_gen.sv
module vg_addr_gen #(
   parameter int LANES_MAX = 8,
   parameter int ELEM_W    = 32,
   parameter int ADDR_W    = 64,
   parameter int DISP_W    = 32,
   parameter int LSEL_W    = 3
) (
   input  logic [LANES_MAX*ELEM_W-1:0] idx_vec,
   input  logic [LSEL_W-1:0]           lane,
   input  logic                        idx64,
   input  logic [1:0]                  scale_code,
   input  logic [ADDR_W-1:0]           base,
   input  logic [DISP_W-1:0]           disp,
   output logic [ADDR_W-1:0]           addr
);
   localparam int WIDE_W = 2 * ELEM_W;

   logic [ELEM_W-1:0] w_narrow;
   logic [WIDE_W-1:0] w_wide;
   logic [ADDR_W-1:0] ext_narrow, ext_wide, ext_disp, ext_idx;

   assign w_narrow   = idx_vec[lane*ELEM_W +: ELEM_W];
   assign w_wide     = idx_vec[lane[LSEL_W-2:0]*WIDE_W +: WIDE_W];
   assign ext_narrow = {{(ADDR_W-ELEM_W){w_narrow[ELEM_W-1]}}, w_narrow};

   generate
      if (ADDR_W == WIDE_W) begin : g_wide_exact
         assign ext_wide = w_wide;
      end else begin : g_wide_sext
         assign ext_wide = {{(ADDR_W-WIDE_W){w_wide[WIDE_W-1]}}, w_wide};
      end
      if (DISP_W == ADDR_W) begin : g_disp_exact
         assign ext_disp = disp;
      end else begin : g_disp_sext
         assign ext_disp = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
      end
   endgenerate

   assign ext_idx = idx64 ? ext_wide : ext_narrow;
   assign addr    = base + (ext_idx << scale_code) + ext_disp;
endmodule

// File: rtl/vg_vec_regs.sv
module vg_vec_regs #(
   parameter int LANES_MAX = 8,
   parameter int ELEM_W    = 32,
   parameter int CNT_W     = 4,
   parameter int LSEL_W    = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        load,
   input  logic [CNT_W-1:0]            n_lanes,
   input  logic [LANES_MAX*ELEM_W-1:0] dest_in,
   input  logic [LANES_MAX*ELEM_W-1:0] mask_in,
   input  logic                        wr_en,
   input  logic                        clr_en,
   input  logic [LSEL_W-1:0]           lane,
   input  logic [ELEM_W-1:0]           wr_data,
   output logic [LANES_MAX*ELEM_W-1:0] dest_q,
   output logic [LANES_MAX*ELEM_W-1:0] mask_q,
   output logic [LANES_MAX-1:0]        lane_act
);
   generate
      for (genvar j = 0; j < LANES_MAX; j++) begin : g_lane
         logic in_shape;
         assign in_shape    = CNT_W'(j) < n_lanes;
         assign lane_act[j] = mask_q[j*ELEM_W + ELEM_W - 1];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               dest_q[j*ELEM_W +: ELEM_W] <= '0;
               mask_q[j*ELEM_W +: ELEM_W] <= '0;
            end else if (load) begin
               dest_q[j*ELEM_W +: ELEM_W] <= in_shape ? dest_in[j*ELEM_W +: ELEM_W] : '0;
               mask_q[j*ELEM_W +: ELEM_W] <=
                  (in_shape && mask_in[j*ELEM_W + ELEM_W - 1]) ? '1 : '0;
            end else begin
               if (wr_en && lane == LSEL_W'(j))
                  dest_q[j*ELEM_W +: ELEM_W] <= wr_data;
               if (clr_en && lane == LSEL_W'(j))
                  mask_q[j*ELEM_W +: ELEM_W] <= '0;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/vg_lane_ctrl.sv
module vg_lane_ctrl
   import vg_pkg::*;
#(
   parameter int LANES_MAX = 8,
   parameter int CNT_W     = 4,
   parameter int LSEL_W    = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [CNT_W-1:0]     n_lanes,
   input  logic [LANES_MAX-1:0] lane_act,
   input  logic                 req_ready,
   input  logic                 rsp_valid,
   input  logic                 rsp_fault,
   output logic                 load,
   output logic                 busy,
   output logic                 req_valid,
   output logic [LSEL_W-1:0]    lane,
   output logic                 wr_en,
   output logic                 clr_en,
   output logic                 done,
   output logic                 fault_o,
   output logic [LSEL_W-1:0]    fault_lane,
   output logic                 resume_o
);
   vg_state_e        state;
   logic [CNT_W-1:0] lane_q;
   logic             got_any;
   logic             lane_end, cur_act, rsp_ok;

   assign lane_end  = lane_q >= n_lanes;
   assign lane      = lane_q[LSEL_W-1:0];
   assign cur_act   = !lane_end && lane_act[lane];
   assign busy      = state != VG_IDLE;
   assign load      = start && state == VG_IDLE;
   assign req_valid = state == VG_SCAN && cur_act;
   assign rsp_ok    = state == VG_WAIT && rsp_valid && !rsp_fault;
   assign wr_en     = rsp_ok;
   assign clr_en    = rsp_ok || (state == VG_SCAN && !lane_end && !cur_act);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= VG_IDLE;
         lane_q     <= '0;
         got_any    <= 1'b0;
         done       <= 1'b0;
         fault_o    <= 1'b0;
         fault_lane <= '0;
         resume_o   <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            VG_IDLE: if (start) begin
               state   <= VG_SCAN;
               lane_q  <= '0;
               got_any <= 1'b0;
            end
            VG_SCAN: begin
               if (lane_end) begin
                  state    <= VG_IDLE;
                  done     <= 1'b1;
                  fault_o  <= 1'b0;
                  resume_o <= 1'b0;
               end else if (!cur_act) begin
                  lane_q <= lane_q + CNT_W'(1);
               end else if (req_ready) begin
                  state <= VG_WAIT;
               end
            end
            VG_WAIT: if (rsp_valid) begin
               if (rsp_fault) begin
                  state      <= VG_IDLE;
                  done       <= 1'b1;
                  fault_o    <= 1'b1;
                  fault_lane <= lane;
                  resume_o   <= got_any;
               end else begin
                  state   <= VG_SCAN;
                  lane_q  <= lane_q + CNT_W'(1);
                  got_any <= 1'b1;
               end
            end
            default: state <= VG_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/vgather_seq.sv
module vgather_seq #(
   parameter int LANES_MAX = 8,
   parameter int ELEM_W    = 32,
   parameter int ADDR_W    = 64,
   parameter int DISP_W    = 32,
   localparam int VEC_W    = LANES_MAX * ELEM_W,
   localparam int CNT_W    = $clog2(LANES_MAX + 1),
   localparam int LSEL_W   = $clog2(LANES_MAX)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               wide_mode,
   input  logic               idx64,
   input  logic [1:0]         scale_code,
   input  logic [ADDR_W-1:0]  base_addr,
   input  logic [DISP_W-1:0]  disp,
   input  logic [VEC_W-1:0]   idx_vec,
   input  logic [VEC_W-1:0]   mask_in,
   input  logic [VEC_W-1:0]   dest_in,
   output logic               busy,
   output logic               done,
   output logic               fault_o,
   output logic [LSEL_W-1:0]  fault_lane,
   output logic               resume_o,
   output logic [VEC_W-1:0]   dest_out,
   output logic [VEC_W-1:0]   mask_out,
   output logic               req_valid,
   input  logic               req_ready,
   output logic [ADDR_W-1:0]  req_addr,
   input  logic               rsp_valid,
   input  logic [ELEM_W-1:0]  rsp_data,
   input  logic               rsp_fault
);
   generate
      if (LANES_MAX < 4 || LANES_MAX % 4 != 0) begin : g_bad_lanes
         $error("LANES_MAX must be a multiple of 4");
      end
      if (ADDR_W < 2 * ELEM_W) begin : g_bad_addr
         $error("ADDR_W must hold a sign-extended wide index");
      end
      if (DISP_W > ADDR_W) begin : g_bad_disp
         $error("DISP_W must not exceed ADDR_W");
      end
   endgenerate

   function automatic logic [CNT_W-1:0] lane_cnt(input logic wide, input logic q64);
      int sh;
      sh = (wide ? 0 : 1) + (q64 ? 1 : 0);
      return CNT_W'(LANES_MAX >> sh);
   endfunction

   logic                 load, wr_en, clr_en;
   logic [LSEL_W-1:0]    lane;
   logic [LANES_MAX-1:0] lane_act;
   logic [VEC_W-1:0]     idx_q;
   logic [ADDR_W-1:0]    base_q;
   logic [DISP_W-1:0]    disp_q;
   logic [1:0]           scale_q;
   logic                 wide_q, q64_q;
   logic [CNT_W-1:0]     n_new, n_run;

   assign n_new = lane_cnt(wide_mode, idx64);
   assign n_run = lane_cnt(wide_q, q64_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q   <= '0;
         base_q  <= '0;
         disp_q  <= '0;
         scale_q <= '0;
         wide_q  <= 1'b0;
         q64_q   <= 1'b0;
      end else if (load) begin
         idx_q   <= idx_vec;
         base_q  <= base_addr;
         disp_q  <= disp;
         scale_q <= scale_code;
         wide_q  <= wide_mode;
         q64_q   <= idx64;
      end
   end

   vg_lane_ctrl #(.LANES_MAX(LANES_MAX), .CNT_W(CNT_W), .LSEL_W(LSEL_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .n_lanes(n_run), .lane_act(lane_act),
      .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
      .load(load), .busy(busy), .req_valid(req_valid), .lane(lane),
      .wr_en(wr_en), .clr_en(clr_en), .done(done), .fault_o(fault_o),
      .fault_lane(fault_lane), .resume_o(resume_o)
   );

   vg_vec_regs #(.LANES_MAX(LANES_MAX), .ELEM_W(ELEM_W), .CNT_W(CNT_W), .LSEL_W(LSEL_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .load(load), .n_lanes(n_new),
      .dest_in(dest_in), .mask_in(mask_in), .wr_en(wr_en), .clr_en(clr_en),
      .lane(lane), .wr_data(rsp_data), .dest_q(dest_out), .mask_q(mask_out),
      .lane_act(lane_act)
   );

   vg_addr_gen #(.LANES_MAX(LANES_MAX), .ELEM_W(ELEM_W), .ADDR_W(ADDR_W),
                 .DISP_W(DISP_W), .LSEL_W(LSEL_W)) u_agen (
      .idx_vec(idx_q), .lane(lane), .idx64(q64_q), .scale_code(scale_q),
      .base(base_q), .disp(disp_q), .addr(req_addr)
   );
endmodule

// File: rtl/vg_gather_chk.sv
module vg_gather_chk #(
   parameter int LANES_MAX = 8,
   parameter int ELEM_W    = 32,
   parameter int ADDR_W    = 64
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           start,
   input logic                           busy,
   input logic                           done,
   input logic                           fault_o,
   input logic [$clog2(LANES_MAX)-1:0]   fault_lane,
   input logic                           resume_o,
   input logic                           req_valid,
   input logic                           req_ready,
   input logic [ADDR_W-1:0]              req_addr,
   input logic [LANES_MAX*ELEM_W-1:0]    mask_out
);
   AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy |=> busy); // R1
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R1
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R1
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_ready |=> req_valid && $stable(req_addr)); // R5
   AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> busy); // R5
   AST_CLEAN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      done && !fault_o |-> mask_out == '0); // R8
   AST_FAULT_LANE_SET: assert property (@(posedge clk) disable iff (!rst_n)
      done && fault_o |-> mask_out[fault_lane*ELEM_W + ELEM_W - 1]); // R9
   AST_RESUME_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      done && resume_o |-> fault_o); // R10
endmodule

bind vgather_seq vg_gather_chk #(.LANES_MAX(LANES_MAX), .ELEM_W(ELEM_W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
   .fault_o(fault_o), .fault_lane(fault_lane), .resume_o(resume_o),
   .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
   .mask_out(mask_out)
);

// File: tb/vgather_seq_bench.sv
module vgather_seq_bench;
   localparam int NL = 8;
   localparam int VW = 256;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic wide_mode = 1'b0, idx64 = 1'b0;
   logic [1:0] scale_code = '0;
   logic [63:0] base_addr = '0;
   logic [31:0] disp = '0;
   logic [VW-1:0] idx_vec = '0, mask_in = '0, dest_in = '0;
   logic busy, done, fault_o, resume_o, req_valid, req_ready, rsp_valid, rsp_fault;
   logic [2:0] fault_lane;
   logic [VW-1:0] dest_out, mask_out;
   logic [63:0] req_addr;
   logic [31:0] rsp_data;

   always #2 clk = ~clk;

   vgather_seq u_vgather_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .wide_mode(wide_mode), .idx64(idx64),
      .scale_code(scale_code), .base_addr(base_addr), .disp(disp), .idx_vec(idx_vec),
      .mask_in(mask_in), .dest_in(dest_in), .busy(busy), .done(done), .fault_o(fault_o),
      .fault_lane(fault_lane), .resume_o(resume_o), .dest_out(dest_out), .mask_out(mask_out),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_fault(rsp_fault)
   );

   int n_tests = 0, n_fail = 0;
   logic [63:0] req_log [16];
   int req_cnt = 0, fault_at = -1, rsp_dly = 0;
   bit stall = 0;

   // expected results
   logic [VW-1:0] e_dest, e_mask;
   logic [63:0] e_addr [16];
   bit e_fault, e_res;
   int e_fl, e_nreq, e_n;

   function automatic logic [31:0] dat(input logic [63:0] a);
      return a[31:0] ^ a[63:32] ^ 32'hC3A5_1E0F;
   endfunction

   function automatic logic [63:0] calc_addr(input logic [63:0] b, input logic [VW-1:0] ix,
         input int j, input bit q, input logic [1:0] sc, input logic [31:0] d);
      logic signed [63:0] iv, dv;
      iv = q ? $signed(ix[64*j +: 64]) : 64'($signed(ix[32*j +: 32]));
      dv = 64'($signed(d));
      return b + iv * (64'd1 << sc) + dv;
   endfunction

   task automatic check(input bit ok, input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model(input bit w, input bit q, input logic [1:0] sc, input logic [63:0] b,
         input logic [31:0] d, input logic [VW-1:0] ix, input logic [VW-1:0] m,
         input logic [VW-1:0] ds, input int fat);
      bit stop = 0;
      int k = 0;
      logic [63:0] a;
      e_n = NL >> ((w ? 0 : 1) + (q ? 1 : 0));
      e_dest = ds; e_mask = '0; e_fault = 0; e_res = 0; e_fl = 0;
      for (int j = 0; j < NL; j++) begin
         if (j >= e_n) e_dest[32*j +: 32] = '0;
         else e_mask[32*j +: 32] = m[32*j+31] ? 32'hFFFF_FFFF : 32'h0;
      end
      for (int j = 0; j < e_n; j++) begin
         if (!stop && m[32*j+31]) begin
            a = calc_addr(b, ix, j, q, sc, d);
            e_addr[k] = a;
            if (k == fat) begin
               stop = 1; e_fault = 1; e_fl = j; e_res = (k > 0);
            end else begin
               e_dest[32*j +: 32] = dat(a);
               e_mask[32*j +: 32] = '0;
            end
            k++;
         end
      end
      e_nreq = k;
   endtask

   // memory model: one request at a time, optional accept stalls and response delay
   initial begin : mem_model
      bit pend = 0, pf = 0;
      int cnt = 0;
      logic [63:0] pa = '0;
      req_ready = 1'b0; rsp_valid = 1'b0; rsp_data = '0; rsp_fault = 1'b0;
      forever begin
         @(negedge clk);
         rsp_valid = 1'b0; rsp_fault = 1'b0;
         if (pend) begin
            req_ready = 1'b0;
            if (cnt == 0) begin
               rsp_valid = 1'b1; rsp_fault = pf;
               rsp_data = pf ? 32'hDEAD_BEEF : dat(pa);
               pend = 0;
            end else cnt--;
         end else begin
            req_ready = stall ? ~req_ready : 1'b1;
            if (req_valid && req_ready) begin
               pa = req_addr;
               if (req_cnt < 16) req_log[req_cnt] = pa;
               pf = (req_cnt == fault_at);
               req_cnt++;
               pend = 1; cnt = rsp_dly;
            end
         end
      end
   end

   task automatic wait_done();
      int t = 0;
      while (!done && t < 2000) begin
         @(negedge clk);
         t++;
      end
      check(done, "R1 done within bound", VW'(done), VW'(1));
   endtask

   task automatic run_chk(input bit w, input bit q, input logic [1:0] sc, input logic [63:0] b,
         input logic [31:0] d, input logic [VW-1:0] ix, input logic [VW-1:0] m,
         input logic [VW-1:0] ds, input int fat, input int dly, input bit stl,
         input bit intrude, input string ctx);
      logic [VW-1:0] low;
      bit ok;
      model(w, q, sc, b, d, ix, m, ds, fat);
      fault_at = fat; rsp_dly = dly; stall = stl; req_cnt = 0;
      @(negedge clk);
      wide_mode = w; idx64 = q; scale_code = sc; base_addr = b; disp = d;
      idx_vec = ix; mask_in = m; dest_in = ds; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy, {"R1 busy after start ", ctx}, VW'(busy), VW'(1));
      if (intrude) begin
         @(negedge clk);
         start = 1'b1; mask_in = '1; dest_in = '0; idx_vec = ~ix; base_addr = ~b;
         @(negedge clk);
         start = 1'b0;
      end
      wait_done();
      low = (e_n == NL) ? '1 : ((VW'(1) << (32 * e_n)) - VW'(1));
      ok = (req_cnt == e_nreq);
      for (int k = 0; k < e_nreq && k < 16; k++) if (req_log[k] !== e_addr[k]) ok = 0;
      check(ok, {"R2/R5 request addresses in lane order ", ctx}, VW'(req_cnt), VW'(e_nreq));
      check(req_cnt == e_nreq, {"R4/R6 request count ", ctx}, VW'(req_cnt), VW'(e_nreq));
      check(dest_out === e_dest, {"R6 destination ", ctx}, dest_out, e_dest);
      check(((dest_out | mask_out) & ~low) == '0, {"R7 upper zero ", ctx},
            (dest_out | mask_out) & ~low, '0);
      check(fault_o == e_fault, {"R9 status ", ctx}, VW'(fault_o), VW'(e_fault));
      if (!e_fault) begin
         check(mask_out == '0, {"R8 mask cleared ", ctx}, mask_out, '0);
      end else begin
         check(mask_out === e_mask, {"R2 R9 partial mask ", ctx}, mask_out, e_mask);
         check(fault_lane == 3'(e_fl), {"R9 fault lane ", ctx}, VW'(fault_lane), VW'(e_fl));
         check(resume_o == e_res, {"R10 resume flag ", ctx}, VW'(resume_o), VW'(e_res));
      end
      if (intrude) check(dest_out === e_dest, "R12 start while busy ignored", dest_out, e_dest);
      @(negedge clk);
      check(!done && !busy, {"R1 done is one cycle ", ctx}, VW'({done, busy}), '0);
   endtask

   function automatic logic [VW-1:0] mask_pat(input int p);
      logic [7:0] act;
      logic [VW-1:0] m;
      act = (p == 0) ? 8'hFF : (p == 1) ? 8'h55 : (p == 2) ? 8'h00 : 8'h61;
      for (int j = 0; j < NL; j++)
         m[32*j +: 32] = act[j] ? {1'b1, 31'(j * 77 + 5)} : {1'b0, 31'(j * 91 + 3)};
      return m;
   endfunction

   function automatic logic [VW-1:0] idx_pat(input bit q, input int r);
      logic [VW-1:0] v;
      for (int j = 0; j < NL; j++) v[32*j +: 32] = 32'(j * 53 - 200 + r);
      if (q) for (int j = 0; j < NL / 2; j++) v[64*j +: 64] = 64'(longint'(77 + r - j * 100000));
      if (q && r % 2 == 1) v[192 +: 64] = 64'h8000_0000_0000_0040;
      return v;
   endfunction

   function automatic logic [VW-1:0] dest_pat(input int r);
      logic [VW-1:0] v;
      for (int j = 0; j < NL; j++) v[32*j +: 32] = 32'hD000_0000 | 32'(r << 8) | 32'(j);
      return v;
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      logic [VW-1:0] full_dest, m1;
      int full_n, r;
      repeat (5) @(negedge clk);
      check(!busy && !done && !req_valid && mask_out == '0, "R1 reset state",
            VW'({busy, done, req_valid}), '0);
      rst_n = 1'b1;
      r = 0;
      // sweep over shape, scale and mask pattern (R3, R4, R6)
      for (int w = 0; w < 2; w++)
         for (int q = 0; q < 2; q++)
            for (int sc = 0; sc < 4; sc++)
               for (int p = 0; p < 4; p++) begin
                  run_chk(w[0], q[0], 2'(sc), 64'h0000_1000_0000_0000 + 64'(r * 4096),
                          (r % 2) ? 32'hFFFF_FF00 : 32'h0000_0340, idx_pat(q[0], r),
                          mask_pat(p), dest_pat(r), -1, r % 3, r[0], 1'b0, "R3 sweep");
                  r++;
               end
      // fault on first request: no resume (R10), normalised mask (R2)
      m1 = '0;
      for (int j = 0; j < NL; j++) m1[32*j +: 32] = 32'h8000_0001;
      run_chk(1'b1, 1'b0, 2'd2, 64'h2000, 32'h10, idx_pat(1'b0, 3), m1, dest_pat(90),
              0, 1, 1'b0, 1'b0, "R9 fault first");
      // fault on fourth request, then restart (R11)
      model(1'b1, 1'b0, 2'd2, 64'h2000, 32'h10, idx_pat(1'b0, 3), m1, dest_pat(91), -1);
      full_dest = e_dest; full_n = e_nreq;
      run_chk(1'b1, 1'b0, 2'd2, 64'h2000, 32'h10, idx_pat(1'b0, 3), m1, dest_pat(91),
              3, 0, 1'b1, 1'b0, "R10 fault later");
      run_chk(1'b1, 1'b0, 2'd2, 64'h2000, 32'h10, idx_pat(1'b0, 3), mask_out, dest_out,
              -1, 2, 1'b0, 1'b0, "R11 restart");
      check(dest_out === full_dest, "R11 restart equals clean run", dest_out, full_dest);
      check(req_cnt == full_n - 3, "R11 only remaining lanes fetched", VW'(req_cnt), VW'(full_n - 3));
      // wide index fault with upper zeroing (R7)
      run_chk(1'b1, 1'b1, 2'd3, 64'hFFFF_FFFF_FFFF_F000, 32'h8000_0000, idx_pat(1'b1, 5),
              mask_pat(1), dest_pat(92), 1, 0, 1'b0, 1'b0, "R7 wide fault");
      // start while busy (R12)
      run_chk(1'b1, 1'b0, 2'd1, 64'h5000, 32'h4, idx_pat(1'b0, 8), mask_pat(0), dest_pat(93),
              -1, 2, 1'b1, 1'b1, "R12 intrude");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule